// File: doc/BRIEF.md
# UART Serial Boot Loader

This block runs a serial boot handshake in hardware. It uses a byte-wide receive stream and a byte-wide transmit stream, both with valid/ready handshakes. After reset it offers a prompt character to the transmitter. Once the transmitter has taken the prompt, the block listens for a four-byte magic signature. Two byte orders of the signature are accepted.

When the signature matches, the block copies a fixed-size image byte by byte into an external load buffer through a plain write port (address, data, write enable). It then sends an acknowledge character. After that it drives the green status LED and gives a one-cycle pulse that tells the processor to start executing from buffer address zero. If the signature is wrong, or the line stays idle for too long while the signature is expected, the block locks into a failure state that blinks the green LED until the next reset.

The UART line coding, the buffer memory and the processor are outside this block. Only the byte streams, the write port, the jump pulse and the two LED outputs appear at its edge.

Top module: `uart_boot_loader`

## Requirements
- R1: In the first cycle after reset is released, `tx_valid` is 1 and `tx_data` is 0x3E ('>'). `led_red` is 1, `led_green` is 0 and `boot_go` is 0. This prompt is the first byte the transmitter receives.
- R2: `rx_ready` stays 0 until the transmitter has accepted the prompt (`tx_valid` and `tx_ready` both 1 at a clock edge). No received byte is consumed before then.
- R3: A signature of 0x43, 0x52, 0x55, 0x53 ("CRUS") is accepted, where 0x43 is the first byte received.
- R4: A signature of 0x53, 0x55, 0x52, 0x43 ("SURC") is accepted, where 0x53 is the first byte received.
- R5: Any other four-byte sequence sends the block to the failure state. After the fourth byte there are no buffer writes, no acknowledge byte and no further `rx_ready`.
- R6: The signature bytes are not written to the buffer. The next IMG_BYTES received bytes are each written exactly once. `wr_en` is high during the cycle of each accepted byte, `wr_data` equals that byte, and `wr_addr` starts at 0 and rises by one per byte.
- R7: After the last payload byte the block offers 0x3C ('<') on `tx_data` with `tx_valid` 1. This byte is held stable until `tx_ready` takes it, and `rx_ready` is 0 meanwhile.
- R8: In the cycle after the acknowledge is accepted, `boot_go` is 1 for exactly one cycle. From that cycle on, `led_green` is 1 and `led_red` is 0.
- R9: During the signature phase, TIMEOUT_CYC clock cycles without an accepted byte send the block to the failure state. The count starts when the prompt is accepted and restarts with each signature byte. A byte that arrives before the limit keeps the boot attempt alive.
- R10: In the failure state `led_red` stays 1. `led_green` starts at 0 and toggles once every BLINK_DIV cycles, counted from entry to the failure state, until reset.
- R11: After the last payload byte has been taken, `rx_ready` and `wr_en` stay 0 until reset, whatever `rx_valid` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte is present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes the received byte this cycle |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit (prompt or acknowledge) |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| wr_en | output | 1 | Load buffer write strobe |
| wr_addr | output | $clog2(IMG_BYTES) | Load buffer write address |
| wr_data | output | 8 | Load buffer write data |
| boot_go | output | 1 | One-cycle request to jump to buffer address zero |
| led_red | output | 1 | Red LED, on while booting or failed |
| led_green | output | 1 | Green LED, steady on success, blinking on failure |

## Verification
The hardest cases to reach from the ports are the timing edges of the listen timeout and the blink phase after a failure. Both depend on knowing the exact clock edge at which the block changes phase. To get there, the stimulus first waits on the port until `rx_ready` rises, which marks the edge where the prompt was accepted. It then either holds the line idle just under the limit before sending a valid signature, or well past the limit. For the wrong-signature case the blink phase is checked on exact cycles counted from the edge that took the fourth byte. The acknowledge stall is reached by holding `tx_ready` low through the end of a full-size payload.

// File: rtl/ubl_pkg.sv
// Package ubl_pkg
// Shared state encoding and character constants for the serial boot loader.
// Assumes 8-bit characters on both byte streams.
package ubl_pkg;

    typedef enum logic [2:0] {
        ST_PROMPT = 3'd0,
        ST_SIG    = 3'd1,
        ST_LOAD   = 3'd2,
        ST_ACK    = 3'd3,
        ST_GO     = 3'd4,
        ST_DONE   = 3'd5,
        ST_FAIL   = 3'd6
    } ubl_state_t;

    localparam logic [7:0]  CHAR_PROMPT = 8'h3E;
    localparam logic [7:0]  CHAR_ACK    = 8'h3C;
    localparam logic [31:0] SIG_MAGIC   = 32'h4352_5553;

endpackage

// File: rtl/ubl_sig_match.sv
// Module ubl_sig_match
// Collects signature bytes and compares them with MAGIC, in forward or
// byte-reversed order. The comparison includes the byte on byte_in, so the
// verdict is ready in the same cycle that the last byte is accepted.
// Assumes clear is held whenever the signature phase is not active.
module ubl_sig_match #(
    parameter int BYTE_W  = 8,
    parameter int SIG_LEN = 4,
    parameter logic [BYTE_W*SIG_LEN-1:0] MAGIC = '0,
    localparam int SW = BYTE_W * SIG_LEN,
    localparam int CW = $clog2(SIG_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              last_slot,
    output logic              match_now
);

    logic [SW-BYTE_W-1:0] hist;
    logic [CW-1:0]        slot;
    logic [SW-1:0]        candidate;
    logic [SW-1:0]        magic_rev;

    // Build the byte-reversed form of the magic word.
    for (genvar i = 0; i < SIG_LEN; i++) begin : g_rev
        assign magic_rev[i*BYTE_W +: BYTE_W] = MAGIC[(SIG_LEN-1-i)*BYTE_W +: BYTE_W];
    end

    // Earlier bytes in the upper part, incoming byte in the lowest slot.
    assign candidate = {hist, byte_in};

    // Keep the earlier signature bytes and count the slots used.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hist <= '0;
            slot <= '0;
        end else if (shift_en) begin
            hist <= candidate[SW-BYTE_W-1:0];
            slot <= slot + 1'b1;
        end
    end

    // Flag the final slot and check both accepted orders.
    always_comb begin
        last_slot = (slot == CW'(SIG_LEN - 1));
        match_now = (candidate == MAGIC) || (candidate == magic_rev);
    end

endmodule

// File: rtl/ubl_timeout.sv
// Module ubl_timeout
// Counts idle cycles while run is high and reports expiry on the LIMIT-th
// idle cycle. A restart in that same cycle takes priority over expiry.
// Assumes LIMIT >= 2.
module ubl_timeout #(
    parameter int LIMIT = 1000,
    localparam int CW = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);

    localparam logic [CW-1:0] TERM = CW'(LIMIT - 1);

    logic [CW-1:0] idle_cnt;

    // Count idle cycles, clearing on restart or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            idle_cnt <= '0;
        end else if (idle_cnt != TERM) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Expiry fires on the terminal count unless a byte arrives.
    always_comb begin
        expired = run && !restart && (idle_cnt == TERM);
    end

endmodule

// File: rtl/ubl_load_ctr.sv
// Module ubl_load_ctr
// Produces the buffer write address and flags the last slot of the image.
// Assumes clear is held outside the payload phase.
module ubl_load_ctr #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);

    // Advance the address once per stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    // Mark the final address of the image.
    always_comb begin
        last = (addr == AW'(DEPTH - 1));
    end

endmodule

// File: rtl/ubl_blink.sv
// Module ubl_blink
// Free-running divider that toggles led every DIV cycles while run is high.
// While run is low the divider and the LED are held at zero.
// Assumes DIV >= 2.
module ubl_blink #(
    parameter int DIV = 1000,
    localparam int CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic led
);

    localparam logic [CW-1:0] TERM = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    // Divide the clock and toggle the LED on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            led     <= 1'b0;
        end else if (div_cnt == TERM) begin
            div_cnt <= '0;
            led     <= ~led;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_boot_loader.sv
// Module uart_boot_loader
// Serial boot handshake sequencer. It sends a prompt, checks a four-byte
// signature, stores a fixed-size image through a write port, sends an
// acknowledge and pulses boot_go. A timeout or a bad signature locks it into
// a blinking failure state until reset.
// Assumes single-clock valid/ready byte streams and a buffer that accepts
// one write per cycle.
module uart_boot_loader #(
    parameter int IMG_BYTES   = 2048,
    parameter int TIMEOUT_CYC = 1_000_000,
    parameter int BLINK_DIV   = 12_500_000,
    localparam int ADDR_W = $clog2(IMG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              boot_go,
    output logic              led_red,
    output logic              led_green
);

    import ubl_pkg::*;

    ubl_state_t state, state_nx;

    logic rx_fire;
    logic tx_fire;
    logic in_sig;
    logic in_load;
    logic in_fail;
    logic sig_last;
    logic sig_ok;
    logic tmo_hit;
    logic load_last;
    logic blink_led;

    // Decode the phase and the handshakes on both byte streams.
    always_comb begin
        in_sig   = (state == ST_SIG);
        in_load  = (state == ST_LOAD);
        in_fail  = (state == ST_FAIL);
        rx_ready = in_sig || in_load;
        tx_valid = (state == ST_PROMPT) || (state == ST_ACK);
        tx_data  = (state == ST_ACK) ? CHAR_ACK : CHAR_PROMPT;
        rx_fire  = rx_valid && rx_ready;
        tx_fire  = tx_valid && tx_ready;
    end

    ubl_sig_match #(
        .BYTE_W  (8),
        .SIG_LEN (4),
        .MAGIC   (SIG_MAGIC)
    ) u_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!in_sig),
        .shift_en  (rx_fire && in_sig),
        .byte_in   (rx_data),
        .last_slot (sig_last),
        .match_now (sig_ok)
    );

    ubl_timeout #(
        .LIMIT (TIMEOUT_CYC)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_sig),
        .restart (rx_fire),
        .expired (tmo_hit)
    );

    ubl_load_ctr #(
        .DEPTH (IMG_BYTES)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!in_load),
        .step  (rx_fire && in_load),
        .addr  (wr_addr),
        .last  (load_last)
    );

    ubl_blink #(
        .DIV (BLINK_DIV)
    ) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_fail),
        .led   (blink_led)
    );

    // Choose the next phase of the handshake.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PROMPT: if (tx_fire) state_nx = ST_SIG;
            ST_SIG: begin
                if (rx_fire && sig_last) state_nx = sig_ok ? ST_LOAD : ST_FAIL;
                else if (tmo_hit)        state_nx = ST_FAIL;
            end
            ST_LOAD:   if (rx_fire && load_last) state_nx = ST_ACK;
            ST_ACK:    if (tx_fire) state_nx = ST_GO;
            ST_GO:     state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_DONE;
            ST_FAIL:   state_nx = ST_FAIL;
            default:   state_nx = ST_FAIL;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PROMPT;
        else        state <= state_nx;
    end

    // Drive the write port, the jump pulse and the LEDs.
    always_comb begin
        wr_en     = in_load && rx_valid;
        wr_data   = rx_data;
        boot_go   = (state == ST_GO);
        led_red   = !((state == ST_GO) || (state == ST_DONE));
        led_green = ((state == ST_GO) || (state == ST_DONE)) ? 1'b1 : blink_led;
    end

endmodule

// File: rtl/ubl_checker.sv
// Module ubl_checker
// Temporal checks on the ports of uart_boot_loader, attached by bind below.
// Keeps its own write count and its own record of a completed boot.
module ubl_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              boot_go,
    input logic              led_red,
    input logic              led_green
);

    logic [ADDR_W-1:0] wcount;
    logic              seen_go;

    // Count buffer writes and note a completed boot since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcount  <= '0;
            seen_go <= 1'b0;
        end else begin
            if (wr_en)   wcount  <= wcount + 1'b1;
            if (boot_go) seen_go <= 1'b1;
        end
    end

    a_r2_quiet_until_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_data == 8'h3E) |-> !rx_ready);

    a_r6_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rx_valid && rx_ready && wr_addr == wcount));

    a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r8_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        boot_go |=> !boot_go);

    a_r8_go_leds: assert property (@(posedge clk) disable iff (!rst_n)
        boot_go |-> (led_green && !led_red));

    a_r11_quiet_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        seen_go |-> (!rx_ready && !wr_en && !tx_valid));

endmodule

bind uart_boot_loader ubl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .boot_go   (boot_go),
    .led_red   (led_red),
    .led_green (led_green)
);

// File: tb/sim_uart_boot_loader.sv
// Scoreboard bench: the stimulus tasks queue the expected writes and
// transmit bytes, and a monitor compares the design's handshakes at the
// falling edge.
module sim_uart_boot_loader;

    localparam int IMG = 2048;
    localparam int TMO = 64;
    localparam int BLK = 16;
    localparam int AW  = $clog2(IMG);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rx_valid;
    logic [7:0]    rx_data;
    logic          rx_ready;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          boot_go;
    logic          led_red;
    logic          led_green;

    always #10 clk = ~clk;

    uart_boot_loader #(
        .IMG_BYTES   (IMG),
        .TIMEOUT_CYC (TMO),
        .BLINK_DIV   (BLK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .boot_go(boot_go), .led_red(led_red),
        .led_green(led_green)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [AW+7:0] wq[$];
    logic [7:0]    tq[$];
    logic [AW+7:0] w_exp;
    logic [7:0]    t_exp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every handshake on the write port and the transmitter.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (wr_en) begin
                if (wq.size() == 0) chk(1'b0, "R11 unexpected write", int'(wr_addr), 0);
                else begin
                    w_exp = wq.pop_front();
                    chk({wr_addr, wr_data} == w_exp, "R6 buffer write",
                        int'({wr_addr, wr_data}), int'(w_exp));
                end
            end
            if (tx_valid && tx_ready) begin
                if (tq.size() == 0) chk(1'b0, "R5 unexpected tx byte", int'(tx_data), 0);
                else begin
                    t_exp = tq.pop_front();
                    chk(tx_data == t_exp, "R1 or R7 tx byte", int'(tx_data), int'(t_exp));
                end
            end
        end
    end

    task automatic do_reset();
        rst_n    = 1'b0;
        rx_valid = 1'b0;
        rx_data  = 8'h00;
        tx_ready = 1'b0;
        wq.delete();
        tq.delete();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic wait_listen();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rx_ready) break;
        end
        chk(rx_ready == 1'b1, "R2 listen after prompt", int'(rx_ready), 1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk);
        #2;
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        @(posedge clk);
        #2 rx_valid = 1'b0;
    endtask

    task automatic send_sig(input logic [31:0] s);
        for (int i = 3; i >= 0; i--) send_byte(s[i*8 +: 8]);
    endtask

    task automatic send_image(input bit alt);
        for (int a = 0; a < IMG; a++) begin
            logic [7:0] d;
            d = alt ? 8'(a ^ (a >> 3)) : 8'(a * 7 + 3);
            wq.push_back({AW'(a), d});
            send_byte(d);
        end
    endtask

    // Ack is taken at the next falling edge; the pulse follows one cycle later.
    task automatic check_go();
        @(negedge clk);
        @(negedge clk);
        chk(boot_go == 1'b1, "R8 jump pulse", int'(boot_go), 1);
        chk(led_green == 1'b1 && led_red == 1'b0, "R8 leds on jump",
            int'({led_green, led_red}), 2);
        @(negedge clk);
        chk(boot_go == 1'b0, "R8 single pulse", int'(boot_go), 0);
        chk(led_green == 1'b1, "R8 green stays", int'(led_green), 1);
    endtask

    task automatic check_ignored_after();
        @(posedge clk);
        #2;
        rx_valid = 1'b1;
        rx_data  = 8'h55;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(rx_ready == 1'b0 && wr_en == 1'b0, "R11 ignore after image",
                int'({rx_ready, wr_en}), 0);
        end
        @(posedge clk);
        #2 rx_valid = 1'b0;
    endtask

    initial begin
        // Case 1: CRUS, ack stalled by the transmitter.
        do_reset();
        @(negedge clk);
        chk(tx_valid == 1'b1 && tx_data == 8'h3E, "R1 prompt offered",
            int'({tx_valid, tx_data}), 'h13E);
        chk(led_red == 1'b1 && led_green == 1'b0 && boot_go == 1'b0, "R1 reset leds",
            int'({led_red, led_green, boot_go}), 4);
        @(posedge clk);
        #2 rx_valid = 1'b1;
        rx_data = 8'h43;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rx_ready == 1'b0 && wr_en == 1'b0, "R2 no listen before prompt",
                int'(rx_ready), 0);
        end
        @(posedge clk);
        #2 rx_valid = 1'b0;
        tq.push_back(8'h3E);
        tx_ready = 1'b1;
        wait_listen();
        @(posedge clk);
        #2 tx_ready = 1'b0;
        send_sig(32'h4352_5553);          // R3
        send_image(1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tx_valid == 1'b1 && tx_data == 8'h3C && rx_ready == 1'b0,
                "R7 ack held", int'({tx_valid, rx_ready, tx_data}), 'h23C);
        end
        tq.push_back(8'h3C);
        @(posedge clk);
        #2 tx_ready = 1'b1;
        check_go();
        check_ignored_after();
        chk(wq.size() == 0, "R3 all writes seen", wq.size(), 0);

        // Case 2: SURC arriving just inside the timeout window.
        do_reset();
        tq.push_back(8'h3E);
        tx_ready = 1'b1;
        wait_listen();
        repeat (TMO - 6) @(negedge clk);
        chk(rx_ready == 1'b1, "R9 still listening", int'(rx_ready), 1);
        send_sig(32'h5355_5243);          // R4
        tq.push_back(8'h3C);
        send_image(1'b1);
        check_go();
        chk(wq.size() == 0 && tq.size() == 0, "R4 all items seen",
            wq.size() + tq.size(), 0);

        // Case 3: wrong signature, exact blink phase.
        do_reset();
        tq.push_back(8'h3E);
        tx_ready = 1'b1;
        wait_listen();
        send_sig(32'h4352_5543);
        @(negedge clk);
        chk(rx_ready == 1'b0 && tx_valid == 1'b0, "R5 stop on bad signature",
            int'({rx_ready, tx_valid}), 0);
        repeat (BLK - 1) @(negedge clk);
        chk(led_green == 1'b0 && led_red == 1'b1, "R10 blink off phase",
            int'({led_green, led_red}), 1);
        @(negedge clk);
        chk(led_green == 1'b1, "R10 first toggle", int'(led_green), 1);
        repeat (BLK - 1) @(negedge clk);
        chk(led_green == 1'b1, "R10 on phase", int'(led_green), 1);
        @(negedge clk);
        chk(led_green == 1'b0, "R10 second toggle", int'(led_green), 0);

        // Case 4: first byte wrong, reversed order otherwise.
        do_reset();
        tq.push_back(8'h3E);
        tx_ready = 1'b1;
        wait_listen();
        send_sig(32'h4355_5243);
        @(negedge clk);
        chk(rx_ready == 1'b0, "R5 mixed order rejected", int'(rx_ready), 0);

        // Case 5: idle line after the prompt.
        do_reset();
        tq.push_back(8'h3E);
        tx_ready = 1'b1;
        wait_listen();
        repeat (TMO + 3) @(negedge clk);
        chk(rx_ready == 1'b0 && led_red == 1'b1, "R9 timeout to failure",
            int'({rx_ready, led_red}), 1);
        begin
            logic g;
            g = led_green;
            repeat (BLK) @(negedge clk);
            chk(led_green != g, "R10 toggles after timeout", int'(led_green), int'(!g));
        end
        chk(tq.size() == 0 && wq.size() == 0, "R5 no stray outputs",
            wq.size() + tq.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule